// File: doc/BRIEF.md
# Card Pick Retry Controller

This controller drives the feed of a card reader. When the reader is ready and a pick is requested, it starts a pick attempt. An attempt opens with a short PICK pulse and a one-cycle attempt-start pulse. The attempt then waits for a good-pick confirmation from the sensing logic, timed by a 6-bit interval counter that advances on a slow clock enable. If no confirmation arrives before the counter wraps, the controller starts another attempt. On the sixth attempt it does not wait for the wrap. It stops at interval count 56 and raises a one-cycle failure pulse, which the surrounding control uses to drop READY.

A confirmed pick moves the controller to the read phase, where BUSY is held until the end-of-card strobe. The controller then returns to idle. In local mode the pick request is treated as always present, so the reader feeds cards continuously while READY stays high. In remote mode only the external pick command starts an attempt.

States: `PS_IDLE` (no attempt in progress), `PS_WAIT` (attempt in progress, waiting for confirmation) and `PS_READ` (card in the read station). Transitions:
- *start* goes from IDLE to WAIT.
- *retry* stays in WAIT and happens on a tick at count 63 when the attempt limit has not been reached.
- *give-up* goes from WAIT to IDLE on the final attempt, on the tick that takes the count to 56.
- *abort* goes from WAIT to IDLE when READY falls.
- *confirm* goes from WAIT to READ on a good-pick pulse.
- *release* goes from READ to IDLE on the end-of-card strobe.

Top module: `card_pick_ctrl`

## Requirements
- R1: While reset is held low, and in the first cycle after reset, `pick_o`, `pcr_o`, `fail_o` and `busy_o` are all 0.
- R2: `pick_o` is 1 exactly while an attempt is in progress and the interval count of that attempt is 0, 1, 2 or 3. It is 0 in every other cycle.
- R3: `pcr_o` is a one-cycle pulse in the first cycle of each attempt. `pick_o` is also 1 in that cycle.
- R4: The interval count starts at 0 for each attempt and advances by one only in cycles where `tick_i` is 1. A tick at count 63 without confirmation starts a new attempt at count 0, which gives another `pcr_o` pulse.
- R5: At most 6 attempts are made. In the sixth attempt, the tick that brings the count to 56 produces a one-cycle `fail_o` pulse and returns the controller to idle. That is 376 ticks after the first attempt began. No further attempt follows unless a new pick request arrives.
- R6: A `good_pick_i` pulse during an attempt clears the counters, ends the PICK pulse and sets `busy_o` from the next cycle. `busy_o` stays 1 until the cycle after `end_of_card_i` is seen. `good_pick_i` takes priority over a tick in the same cycle.
- R7: With `local_mode_i` = 1 and `ready_i` = 1, an attempt starts from idle without `pick_cmd_i`. This includes the cycle after each end-of-card release, so cards feed continuously.
- R8: With `local_mode_i` = 0, an attempt starts only when `pick_cmd_i` and `ready_i` are both 1 in idle. A pick command while `busy_o` is 1 or `ready_i` is 0 has no effect.
- R9: If `ready_i` falls during an attempt, the controller returns to idle in the next cycle. It produces no failure pulse and no further attempts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ready_i | input | 1 | Reader ready level |
| pick_cmd_i | input | 1 | Pick request from the host (remote mode) |
| local_mode_i | input | 1 | 1 = local mode (request always present), 0 = remote mode |
| good_pick_i | input | 1 | One-cycle good-pick confirmation |
| end_of_card_i | input | 1 | One-cycle end-of-card strobe |
| tick_i | input | 1 | Slow interval clock enable (nominally 1.2 kHz) |
| pick_o | output | 1 | Pick pulse to the feed mechanism |
| pcr_o | output | 1 | Attempt-start pulse |
| fail_o | output | 1 | Pick failure pulse |
| busy_o | output | 1 | Card in read station |

## Verification
The assertions assume the following about the inputs:
- `good_pick_i` and `end_of_card_i` arrive as single-cycle pulses.
- The sensing side sends confirmation only while an attempt is waiting.
- The end-of-card strobe comes only while a card is being read.

The stimulus keeps within these assumptions by raising each of these pulses for exactly one cycle, and only after the corresponding phase has been observed at the outputs. The tick enable is generated at a fixed one-in-four rate. Because of that rate, the 376-tick failure window can be measured directly from the ticks driven.

// File: rtl/card_pick_pkg.sv
package card_pick_pkg;

    typedef enum logic [1:0] {
        PS_IDLE = 2'd0,
        PS_WAIT = 2'd1,
        PS_READ = 2'd2
    } pick_state_e;

endpackage

// File: rtl/pick_timer.sv
module pick_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             adv_i,
    output logic [CNT_W-1:0] count_o
);
    logic [CNT_W-1:0] count_q;

    // Natural wrap from all-ones to zero gives the retry restart.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            count_q <= '0;
        end else if (adv_i) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign count_o = count_q;
endmodule

// File: rtl/attempt_counter.sv
module attempt_counter #(
    parameter int MAX_ATTEMPTS = 6,
    parameter int ATT_W        = $clog2(MAX_ATTEMPTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             load_one_i,
    input  logic             inc_i,
    output logic [ATT_W-1:0] count_o
);
    logic [ATT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            count_q <= '0;
        end else if (load_one_i) begin
            count_q <= ATT_W'(1);
        end else if (inc_i) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign count_o = count_q;

    // R5: the attempt number never exceeds the configured limit
    a_r5_attempt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= ATT_W'(MAX_ATTEMPTS));
endmodule

// File: rtl/pick_fsm.sv
module pick_fsm
    import card_pick_pkg::*;
#(
    parameter int CNT_W        = 6,
    parameter int MAX_ATTEMPTS = 6,
    parameter int FAIL_AT      = 56,
    parameter int PULSE_LAST   = 3,
    parameter int ATT_W        = $clog2(MAX_ATTEMPTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ready_i,
    input  logic             pick_cmd_i,
    input  logic             local_mode_i,
    input  logic             good_pick_i,
    input  logic             end_of_card_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] ctl_count_i,
    input  logic [ATT_W-1:0] attempt_i,
    output logic             tmr_clear_o,
    output logic             tmr_adv_o,
    output logic             att_clear_o,
    output logic             att_load_o,
    output logic             att_inc_o,
    output logic             pick_o,
    output logic             pcr_o,
    output logic             fail_o,
    output logic             busy_o
);
    localparam logic [CNT_W-1:0] CNT_TOP    = '1;
    localparam logic [CNT_W-1:0] FAIL_PRE   = CNT_W'(FAIL_AT - 1);
    localparam logic [CNT_W-1:0] PULSE_END  = CNT_W'(PULSE_LAST);
    localparam logic [ATT_W-1:0] ATT_LAST   = ATT_W'(MAX_ATTEMPTS);

    pick_state_e st_q, st_d;
    logic        pcr_set, fail_set;
    logic        pcr_q, fail_q;
    logic        request;
    logic        last_attempt;

    assign request      = ready_i && (pick_cmd_i || local_mode_i);
    assign last_attempt = (attempt_i == ATT_LAST);

    // Next state and counter control
    always_comb begin
        st_d        = st_q;
        tmr_clear_o = 1'b0;
        tmr_adv_o   = 1'b0;
        att_clear_o = 1'b0;
        att_load_o  = 1'b0;
        att_inc_o   = 1'b0;
        pcr_set     = 1'b0;
        fail_set    = 1'b0;
        unique case (st_q)
            PS_IDLE: begin
                if (request) begin                 // start
                    st_d        = PS_WAIT;
                    tmr_clear_o = 1'b1;
                    att_load_o  = 1'b1;
                    pcr_set     = 1'b1;
                end
            end
            PS_WAIT: begin
                if (!ready_i) begin                // abort
                    st_d        = PS_IDLE;
                    tmr_clear_o = 1'b1;
                    att_clear_o = 1'b1;
                end else if (good_pick_i) begin    // confirm
                    st_d        = PS_READ;
                    tmr_clear_o = 1'b1;
                    att_clear_o = 1'b1;
                end else if (tick_i) begin
                    if (last_attempt && ctl_count_i == FAIL_PRE) begin  // give-up
                        st_d        = PS_IDLE;
                        fail_set    = 1'b1;
                        tmr_clear_o = 1'b1;
                        att_clear_o = 1'b1;
                    end else if (ctl_count_i == CNT_TOP) begin          // retry
                        tmr_adv_o = 1'b1;
                        att_inc_o = 1'b1;
                        pcr_set   = 1'b1;
                    end else begin
                        tmr_adv_o = 1'b1;
                    end
                end
            end
            PS_READ: begin
                if (end_of_card_i) begin           // release
                    st_d = PS_IDLE;
                end
            end
            default: st_d = PS_IDLE;
        endcase
    end

    // State register and registered pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= PS_IDLE;
            pcr_q  <= 1'b0;
            fail_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            pcr_q  <= pcr_set;
            fail_q <= fail_set;
        end
    end

    // Outputs
    always_comb begin
        pick_o = 1'b0;
        busy_o = 1'b0;
        unique case (st_q)
            PS_WAIT: pick_o = (ctl_count_i <= PULSE_END);
            PS_READ: busy_o = 1'b1;
            default: ;
        endcase
        pcr_o  = pcr_q;
        fail_o = fail_q;
    end

    // R4: interval count holds in waiting cycles without a tick
    a_r4_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PS_WAIT && !tick_i && ready_i && !good_pick_i) |=> $stable(ctl_count_i));
    // R6: read phase persists until end of card
    a_r6_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PS_READ && !end_of_card_i) |=> (st_q == PS_READ));
    // R9: losing ready while waiting returns to idle without failure
    a_r9_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PS_WAIT && !ready_i) |=> (st_q == PS_IDLE && !fail_q));
    // R8: remote idle with no command stays idle
    a_r8_no_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PS_IDLE && !local_mode_i && !pick_cmd_i) |=> (st_q == PS_IDLE));
endmodule

// File: rtl/card_pick_ctrl.sv
module card_pick_ctrl
    import card_pick_pkg::*;
#(
    parameter int CNT_W        = 6,
    parameter int MAX_ATTEMPTS = 6,
    parameter int FAIL_AT      = 56,
    parameter int PULSE_LAST   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ready_i,
    input  logic pick_cmd_i,
    input  logic local_mode_i,
    input  logic good_pick_i,
    input  logic end_of_card_i,
    input  logic tick_i,
    output logic pick_o,
    output logic pcr_o,
    output logic fail_o,
    output logic busy_o
);
    localparam int ATT_W = $clog2(MAX_ATTEMPTS + 1);

    logic [CNT_W-1:0] ctl_count;
    logic [ATT_W-1:0] attempt;
    logic tmr_clear, tmr_adv, att_clear, att_load, att_inc;

    pick_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (tmr_clear),
        .adv_i   (tmr_adv),
        .count_o (ctl_count)
    );

    attempt_counter #(.MAX_ATTEMPTS(MAX_ATTEMPTS), .ATT_W(ATT_W)) u_attempts (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (att_clear),
        .load_one_i (att_load),
        .inc_i      (att_inc),
        .count_o    (attempt)
    );

    pick_fsm #(
        .CNT_W(CNT_W), .MAX_ATTEMPTS(MAX_ATTEMPTS), .FAIL_AT(FAIL_AT),
        .PULSE_LAST(PULSE_LAST), .ATT_W(ATT_W)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .ready_i       (ready_i),
        .pick_cmd_i    (pick_cmd_i),
        .local_mode_i  (local_mode_i),
        .good_pick_i   (good_pick_i),
        .end_of_card_i (end_of_card_i),
        .tick_i        (tick_i),
        .ctl_count_i   (ctl_count),
        .attempt_i     (attempt),
        .tmr_clear_o   (tmr_clear),
        .tmr_adv_o     (tmr_adv),
        .att_clear_o   (att_clear),
        .att_load_o    (att_load),
        .att_inc_o     (att_inc),
        .pick_o        (pick_o),
        .pcr_o         (pcr_o),
        .fail_o        (fail_o),
        .busy_o        (busy_o)
    );

    // R3: attempt-start pulse lasts one cycle and coincides with PICK
    a_r3_pcr_single: assert property (@(posedge clk) disable iff (!rst_n)
        pcr_o |=> !pcr_o);
    a_r3_pcr_with_pick: assert property (@(posedge clk) disable iff (!rst_n)
        pcr_o |-> pick_o);
    // R5: failure pulse lasts one cycle and leaves no pick running
    a_r5_fail_single: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |=> !fail_o);
    a_r5_fail_idle: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> (!pick_o && !busy_o));
    // R6: no pick pulse while a card is being read
    a_r6_busy_no_pick: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !pick_o);
endmodule

// File: tb/card_pick_ctrl_tb.sv
module card_pick_ctrl_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ready_i = 1'b0, pick_cmd_i = 1'b0, local_mode_i = 1'b0;
    logic good_pick_i = 1'b0, end_of_card_i = 1'b0, tick_i = 1'b0;
    logic pick_o, pcr_o, fail_o, busy_o;

    int errors = 0, checks = 0;
    int pcr_cnt = 0, fail_cnt = 0, tick_run = 0;
    bit arm = 0, run_on = 0;
    int div = 0;

    // reference model state
    int m_st = 0, m_ctl = 0, m_att = 0;
    bit m_pcr = 0, m_fail = 0;

    always #5 clk = ~clk;

    card_pick_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .ready_i(ready_i), .pick_cmd_i(pick_cmd_i),
        .local_mode_i(local_mode_i), .good_pick_i(good_pick_i),
        .end_of_card_i(end_of_card_i), .tick_i(tick_i),
        .pick_o(pick_o), .pcr_o(pcr_o), .fail_o(fail_o), .busy_o(busy_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // slow enable: one cycle in four
    always @(negedge clk) begin
        div = (div + 1) % 4;
        tick_i = (div == 3);
    end

    // behavioural reference: 0 idle, 1 waiting, 2 reading
    always @(posedge clk) begin
        bit np, nf;
        np = 0; nf = 0;
        if (!rst_n) begin
            m_st = 0; m_ctl = 0; m_att = 0;
        end else begin
            if (m_st == 0) begin
                if (ready_i && (pick_cmd_i || local_mode_i)) begin
                    m_st = 1; m_ctl = 0; m_att = 1; np = 1;
                end
            end else if (m_st == 1) begin
                if (!ready_i) m_st = 0;
                else if (good_pick_i) m_st = 2;
                else if (tick_i) begin
                    if (m_att == 6 && m_ctl + 1 == 56) begin m_st = 0; nf = 1; end
                    else if (m_ctl == 63) begin m_ctl = 0; m_att++; np = 1; end
                    else m_ctl++;
                end
            end else if (end_of_card_i) m_st = 0;
        end
        m_pcr = np; m_fail = nf;
        if (run_on && tick_i) tick_run++;
    end

    // per-cycle comparison and pulse monitors
    always @(negedge clk) begin
        if (rst_n) begin
            bit ep, eb;
            ep = (m_st == 1) && (m_ctl <= 3);
            eb = (m_st == 2);
            chk(pick_o == ep, "R2 pick", pick_o, ep);
            chk(pcr_o == m_pcr, "R3 pcr", pcr_o, m_pcr);
            chk(fail_o == m_fail, "R5 fail", fail_o, m_fail);
            chk(busy_o == eb, "R6 busy", busy_o, eb);
            if (pcr_o) begin
                pcr_cnt++;
                if (arm && !run_on && tick_run == 0) run_on = 1;
            end
            if (fail_o) begin fail_cnt++; run_on = 0; end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_cmd();
        @(negedge clk) pick_cmd_i = 1; @(negedge clk) pick_cmd_i = 0;
    endtask
    task automatic pulse_good();
        @(negedge clk) good_pick_i = 1; @(negedge clk) good_pick_i = 0;
    endtask
    task automatic pulse_eoc();
        @(negedge clk) end_of_card_i = 1; @(negedge clk) end_of_card_i = 0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        cyc(4);
        chk({pick_o, pcr_o, fail_o, busy_o} == 4'b0, "R1 outputs in reset",
            {pick_o, pcr_o, fail_o, busy_o}, 0);
        rst_n = 1;
        cyc(1);
        chk({pick_o, pcr_o, fail_o, busy_o} == 4'b0, "R1 outputs after reset",
            {pick_o, pcr_o, fail_o, busy_o}, 0);

        // R8: command ignored while not ready
        pick_cmd_i = 1; cyc(10); pick_cmd_i = 0; cyc(2);
        chk(pcr_cnt == 0, "R8 cmd ignored when not ready", pcr_cnt, 0);

        // remote pick, confirmation, command ignored while busy
        ready_i = 1; cyc(3);
        pulse_cmd(); cyc(30);
        chk(pcr_cnt == 1, "R3 one attempt started", pcr_cnt, 1);
        pulse_good(); cyc(1);
        chk(busy_o == 1, "R6 busy after good pick", busy_o, 1);
        pulse_cmd(); cyc(20);
        chk(pcr_cnt == 1, "R8 cmd ignored while busy", pcr_cnt, 1);
        pulse_eoc(); cyc(1);
        chk(busy_o == 0, "R6 busy released", busy_o, 0);
        cyc(20);
        chk(pcr_cnt == 1, "R8 remote no restart", pcr_cnt, 1);

        // R4: retries, confirmed in third attempt
        pcr_cnt = 0;
        pulse_cmd();
        for (int i = 0; i < 3000 && pcr_cnt < 3; i++) @(negedge clk);
        cyc(10);
        pulse_good(); cyc(1);
        chk(pcr_cnt == 3, "R4 retry attempts", pcr_cnt, 3);
        chk(busy_o == 1, "R6 busy after retries", busy_o, 1);
        pulse_eoc(); cyc(3);

        // R5: full failure sequence
        pcr_cnt = 0; fail_cnt = 0; tick_run = 0; arm = 1;
        pulse_cmd();
        for (int i = 0; i < 5000 && fail_cnt == 0; i++) @(negedge clk);
        arm = 0;
        chk(pcr_cnt == 6, "R5 six attempts", pcr_cnt, 6);
        chk(fail_cnt == 1, "R5 one failure pulse", fail_cnt, 1);
        chk(tick_run == 376, "R5 ticks to failure", tick_run, 376);
        cyc(300);
        chk(fail_cnt == 1 && pcr_cnt == 6, "R5 no attempt after failure", pcr_cnt, 6);

        // R9: abort on loss of ready
        pcr_cnt = 0; fail_cnt = 0;
        pulse_cmd(); cyc(8);
        ready_i = 0; cyc(2);
        chk(pick_o == 0, "R9 pick stops on abort", pick_o, 0);
        cyc(600);
        chk(fail_cnt == 0, "R9 no failure after abort", fail_cnt, 0);
        chk(pcr_cnt == 1, "R9 no further attempts", pcr_cnt, 1);

        // R7: local mode feeds continuously
        pcr_cnt = 0;
        local_mode_i = 1; ready_i = 1; cyc(5);
        chk(pcr_cnt == 1, "R7 local start without cmd", pcr_cnt, 1);
        pulse_good(); cyc(4);
        pulse_eoc(); cyc(3);
        chk(pcr_cnt == 2, "R7 local restart after end of card", pcr_cnt, 2);
        ready_i = 0; cyc(5);

        finish_run();
    end
endmodule